// File: doc/BRIEF.md
# Accelerometer SPI Bring-Up and Sample Streamer

This block is the SPI master for a three-axis digital accelerometer. After reset it reads the sensor's identity register and compares the byte it gets back with the expected value. If the byte is wrong it raises a sticky error flag and issues no further frames. If the byte is correct it writes a fixed three-frame configuration: full-resolution ±16 g range, then measurement on, then the data-ready interrupt enabled. It then waits a settle time before it accepts any data-ready event.

Once streaming, each low-to-high transition of the sensor's data-ready line starts one chip-select frame. That frame sends a single burst-read command and then clocks in six data bytes. The block joins each axis's high byte above its low byte to form a signed 16-bit sample. The three samples leave on a valid/ready stream. The serial clock runs in mode 3: it idles high, the controller changes MOSI on falling edges, and both sides sample on rising edges, MSB first. The serial half-period, the gap between frames, the settle time and the depth of the input synchroniser are all parameters.

Back-pressure rules on the sample stream are as follows. A sample is transferred on a cycle where valid and ready are both high. While valid is high and ready is low, the sample and valid hold steady. The block remembers one data-ready edge that arrives in that time, and it starts the burst for that edge only after the held sample has been accepted. Any further edges before that burst starts merge into the one remembered edge.

Top module: `accel_spi_ctrl`

## Requirements
- R1: SCLK is high whenever CS_N is high. CS_N falls exactly HALF_DIV clocks before the first SCLK fall of a frame and rises exactly HALF_DIV clocks after the last SCLK rise. CS_N stays high for at least GAP_CYC clocks between frames. MOSI changes only on SCLK falls and carries the MSB of each byte first. In the command byte, bit 7 set means read, bit 6 set means multibyte, and bits 5:0 hold the register address.
- R2: The first frame after reset is 16 clocks long with command 0x80, which reads address 0x00. If the second byte returned is not 0xE5, id_err goes high and stays high until reset, and no further frame is issued.
- R3: When the identity matches, three 16-clock write frames follow in this order: command 0x31 with data 0x0B, command 0x2D with data 0x08, and command 0x2E with data 0x80.
- R4: Data-ready edges that occur before the configuration completes, or within SETTLE_CYC clocks after it, are discarded. They start no frame, either at the time or later.
- R5: After settling, each low-to-high transition of drdy starts exactly one burst. Holding drdy high starts no further burst.
- R6: A burst is a single frame of 56 clocks with command 0xF2. Bytes 1 to 6 of the frame are, in order, X low, X high, Y low, Y high, Z low and Z high.
- R7: smp_x, smp_y and smp_z are {high byte, low byte} for their axis, in twos complement. When ready is high, smp_valid is high for exactly one clock per burst.
- R8: While smp_valid is high and smp_ready is low, the samples and smp_valid stay stable and no new burst starts. One edge that arrives in this time is remembered and served after acceptance. An edge that is registered in the same clock as the remembered edge is consumed is also kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_i | input | 1 | Sensor data-ready line, asynchronous |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to sensor |
| spi_miso_i | input | 1 | Serial data from sensor |
| id_err_o | output | 1 | Identity mismatch, sticky until reset |
| smp_valid_o | output | 1 | Sample set valid |
| smp_ready_i | input | 1 | Consumer accepts sample set |
| smp_x_o | output | 16 | Signed X sample |
| smp_y_o | output | 16 | Signed Y sample |
| smp_z_o | output | 16 | Signed Z sample |

## Verification
Two events can land in the same clock. The first is the start of the queued burst, which consumes the remembered data-ready edge as soon as a held sample is accepted. The second is a new data-ready edge leaving the synchroniser. To provoke this, the bench stalls the stream with one sample held and a second edge queued, then raises ready and fires a third edge at every offset from zero to five clocks after ready rises, so one of those offsets hits the collision cycle. Each offset is judged by the number of sample sets delivered, which must be three, and by their contents: the held set first, then two sets read from the updated sensor registers.

// File: rtl/accel_pkg.sv
package accel_pkg;

  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 2 * BYTE_W;
  localparam int AXES        = 3;
  localparam int MAX_BYTES   = 7;
  localparam int BIDX_W      = $clog2(MAX_BYTES + 1);
  localparam int BIT_W       = BIDX_W + 3;
  localparam int CFG_STEPS   = 3;

  localparam logic [5:0]        ID_ADDR   = 6'h00;
  localparam logic [BYTE_W-1:0] ID_VALUE  = 8'hE5;
  localparam logic [5:0]        DATA_ADDR = 6'h32;
  localparam logic [BIDX_W-1:0] LAST_IDX  = BIDX_W'(2 * AXES);

  typedef enum logic [2:0] {
    E_IDLE, E_LEAD, E_RUN, E_TRAIL, E_GAP
  } eng_state_t;

  typedef enum logic [2:0] {
    C_ID_GO, C_ID_WAIT, C_ERR, C_CFG_GO, C_CFG_WAIT, C_SETTLE, C_STREAM, C_BURST
  } ctl_state_t;

  function automatic logic [BYTE_W-1:0] cmd_byte(input logic rd, input logic mb,
                                                 input logic [5:0] addr);
    return {rd, mb, addr};
  endfunction

  function automatic logic [WORD_W-1:0] cfg_step(input logic [1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      2'd0:    w = {cmd_byte(1'b0, 1'b0, 6'h31), 8'h0B};
      2'd1:    w = {cmd_byte(1'b0, 1'b0, 6'h2D), 8'h08};
      default: w = {cmd_byte(1'b0, 1'b0, 6'h2E), 8'h80};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/accel_spi_shift.sv
module accel_spi_shift
  import accel_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   tx_word,
  input  logic [BIDX_W-1:0]   nbytes,
  input  logic                miso,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                rx_stb,
  output logic [BIDX_W-1:0]   rx_idx,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic                done
);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int CW = (HW > GW) ? HW : GW;

  eng_state_t          st;
  logic [CW-1:0]       cnt;
  logic [WORD_W-1:0]   sh_tx;
  logic [BYTE_W-1:0]   rx_sh;
  logic [BIT_W-1:0]    bitcnt;
  logic [BIT_W-1:0]    last_bit;
  logic                half_tick;
  logic                gap_tick;
  logic [BYTE_W-1:0]   rx_nxt;

  assign half_tick = (cnt == CW'(HALF_DIV - 1));
  assign gap_tick  = (cnt == CW'(GAP_CYC - 1));
  assign rx_nxt    = {rx_sh[BYTE_W-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      cnt      <= '0;
      sh_tx    <= '0;
      rx_sh    <= '0;
      bitcnt   <= '0;
      last_bit <= '0;
      sclk     <= 1'b1;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      rx_stb   <= 1'b0;
      rx_idx   <= '0;
      rx_byte  <= '0;
      done     <= 1'b0;
    end else begin
      rx_stb <= 1'b0;
      done   <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            st       <= E_LEAD;
            cs_n     <= 1'b0;
            cnt      <= '0;
            sh_tx    <= tx_word;
            bitcnt   <= '0;
            last_bit <= {nbytes, 3'b000} - BIT_W'(1);
          end
        end
        E_LEAD: begin
          if (half_tick) begin
            cnt   <= '0;
            sclk  <= 1'b0;
            mosi  <= sh_tx[WORD_W-1];
            sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
            st    <= E_RUN;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_RUN: begin
          if (half_tick) begin
            cnt <= '0;
            if (!sclk) begin
              sclk   <= 1'b1;
              rx_sh  <= rx_nxt;
              bitcnt <= bitcnt + BIT_W'(1);
              if (bitcnt[2:0] == 3'd7) begin
                rx_stb  <= 1'b1;
                rx_byte <= rx_nxt;
                rx_idx  <= bitcnt[BIT_W-1:3];
              end
              if (bitcnt == last_bit) st <= E_TRAIL;
            end else begin
              sclk  <= 1'b0;
              mosi  <= sh_tx[WORD_W-1];
              sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_TRAIL: begin
          if (half_tick) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            st   <= E_GAP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_GAP: begin
          if (gap_tick) begin
            cnt  <= '0;
            done <= 1'b1;
            st   <= E_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/accel_drdy_edge.sv
module accel_drdy_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_i,
  input  logic en,
  input  logic take,
  output logic pend
);
  logic [SYNC_STAGES:0] sh;
  logic                 rise;

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      pend <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-1:0], drdy_i};
      // a new edge wins over consumption of the remembered one
      pend <= en & (rise | (pend & ~take));
    end
  end

endmodule

// File: rtl/accel_sample_pack.sv
module accel_sample_pack
  import accel_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic                          rx_stb,
  input  logic [BIDX_W-1:0]             rx_idx,
  input  logic [BYTE_W-1:0]             rx_byte,
  input  logic                          ready,
  output logic                          valid,
  output logic [AXES-1:0][WORD_W-1:0]   smp
);
  localparam int STG = 2 * AXES - 1;

  logic [BYTE_W-1:0] stg [STG];
  logic              last_hit;

  assign last_hit = cap_en && rx_stb && (rx_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STG; i++) stg[i] <= '0;
    end else if (cap_en && rx_stb) begin
      for (int i = 0; i < STG; i++)
        if (rx_idx == BIDX_W'(i + 1)) stg[i] <= rx_byte;
    end
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [BYTE_W-1:0] hi;
    if (a == AXES - 1) begin : g_last
      assign hi = rx_byte;
    end else begin : g_mid
      assign hi = stg[2*a+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        smp[a] <= '0;
      else if (last_hit) smp[a] <= {hi, stg[2*a]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid <= 1'b0;
    else if (last_hit) valid <= 1'b1;
    else if (ready)    valid <= 1'b0;
  end

endmodule

// File: rtl/accel_spi_ctrl.sv
module accel_spi_ctrl
  import accel_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int GAP_CYC     = 4,
  parameter int SETTLE_CYC  = 137500,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drdy_i,
  output logic        spi_sclk_o,
  output logic        spi_cs_n_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i,
  output logic        id_err_o,
  output logic        smp_valid_o,
  input  logic        smp_ready_i,
  output logic [15:0] smp_x_o,
  output logic [15:0] smp_y_o,
  output logic [15:0] smp_z_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  ctl_state_t                 st;
  logic [1:0]                 cfg_idx;
  logic [SW-1:0]              settle_cnt;
  logic                       eng_start;
  logic [WORD_W-1:0]          eng_tx;
  logic [BIDX_W-1:0]          eng_nb;
  logic                       eng_done;
  logic                       rx_stb;
  logic [BIDX_W-1:0]          rx_idx;
  logic [BYTE_W-1:0]          rx_byte;
  logic                       pend;
  logic                       take;
  logic                       edge_en;
  logic [AXES-1:0][WORD_W-1:0] smp;

  assign edge_en = (st == C_STREAM) || (st == C_BURST);
  assign take    = (st == C_STREAM) && pend && !smp_valid_o;
  assign id_err_o = (st == C_ERR);
  assign smp_x_o = smp[0];
  assign smp_y_o = smp[1];
  assign smp_z_o = smp[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= C_ID_GO;
      cfg_idx    <= '0;
      settle_cnt <= '0;
      eng_start  <= 1'b0;
      eng_tx     <= '0;
      eng_nb     <= '0;
    end else begin
      eng_start <= 1'b0;
      case (st)
        C_ID_GO: begin
          eng_start <= 1'b1;
          eng_tx    <= {cmd_byte(1'b1, 1'b0, ID_ADDR), 8'h00};
          eng_nb    <= BIDX_W'(2);
          st        <= C_ID_WAIT;
        end
        C_ID_WAIT: begin
          if (eng_done) st <= (rx_byte == ID_VALUE) ? C_CFG_GO : C_ERR;
        end
        C_ERR: st <= C_ERR;
        C_CFG_GO: begin
          eng_start <= 1'b1;
          eng_tx    <= cfg_step(cfg_idx);
          eng_nb    <= BIDX_W'(2);
          st        <= C_CFG_WAIT;
        end
        C_CFG_WAIT: begin
          if (eng_done) begin
            if (cfg_idx == 2'(CFG_STEPS - 1)) begin
              st         <= C_SETTLE;
              settle_cnt <= '0;
            end else begin
              cfg_idx <= cfg_idx + 2'd1;
              st      <= C_CFG_GO;
            end
          end
        end
        C_SETTLE: begin
          if (settle_cnt == SW'(SETTLE_CYC - 1)) st <= C_STREAM;
          else settle_cnt <= settle_cnt + SW'(1);
        end
        C_STREAM: begin
          if (take) begin
            eng_start <= 1'b1;
            eng_tx    <= {cmd_byte(1'b1, 1'b1, DATA_ADDR), 8'h00};
            eng_nb    <= BIDX_W'(2 * AXES + 1);
            st        <= C_BURST;
          end
        end
        C_BURST: begin
          if (eng_done) st <= C_STREAM;
        end
        default: st <= C_ID_GO;
      endcase
    end
  end

  accel_spi_shift #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .tx_word(eng_tx),
    .nbytes (eng_nb),
    .miso   (spi_miso_i),
    .sclk   (spi_sclk_o),
    .cs_n   (spi_cs_n_o),
    .mosi   (spi_mosi_o),
    .rx_stb (rx_stb),
    .rx_idx (rx_idx),
    .rx_byte(rx_byte),
    .done   (eng_done)
  );

  accel_drdy_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .drdy_i(drdy_i),
    .en    (edge_en),
    .take  (take),
    .pend  (pend)
  );

  accel_sample_pack u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (st == C_BURST),
    .rx_stb (rx_stb),
    .rx_idx (rx_idx),
    .rx_byte(rx_byte),
    .ready  (smp_ready_i),
    .valid  (smp_valid_o),
    .smp    (smp)
  );

endmodule

// File: rtl/accel_spi_ctrl_chk.sv
module accel_spi_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_sclk_o,
  input logic        spi_cs_n_o,
  input logic        id_err_o,
  input logic        smp_valid_o,
  input logic        smp_ready_i,
  input logic [15:0] smp_x_o,
  input logic [15:0] smp_y_o,
  input logic [15:0] smp_z_o
);

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> spi_sclk_o); // R1

  AST_CS_EDGE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n_o) || $rose(spi_cs_n_o)) |-> spi_sclk_o); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    id_err_o |=> id_err_o); // R2

  AST_ERR_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    id_err_o |-> (spi_cs_n_o && spi_sclk_o)); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && smp_ready_i) |=> !smp_valid_o); // R7

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_x_o) &&
                                       $stable(smp_y_o) && $stable(smp_z_o))); // R8

endmodule

bind accel_spi_ctrl accel_spi_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_sclk_o (spi_sclk_o),
  .spi_cs_n_o (spi_cs_n_o),
  .id_err_o   (id_err_o),
  .smp_valid_o(smp_valid_o),
  .smp_ready_i(smp_ready_i),
  .smp_x_o    (smp_x_o),
  .smp_y_o    (smp_y_o),
  .smp_z_o    (smp_z_o)
);

// File: tb/sim_accel_spi_ctrl.sv
`timescale 1ns/1ps
module sim_accel_spi_ctrl;
  localparam int HALF   = 2;
  localparam int GAP    = 3;
  localparam int SETTLE = 300;
  localparam int NVEC   = 5;
  // each entry: {x, y, z}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0001, 16'hFFFF, 16'h0000},
    {16'h0FFF, 16'hF000, 16'h0100},
    {16'hFF00, 16'h00FF, 16'h8001},
    {16'h1234, 16'hEDCB, 16'h7F80},
    {16'hA55A, 16'h5AA5, 16'hFFFE}
  };

  logic clk = 1'b0, rst_n = 1'b0, drdy = 1'b0, ready = 1'b0;
  logic sclk, cs_n, mosi, miso = 1'b0, id_err, valid;
  logic [15:0] sx, sy, sz;

  always #4 clk = ~clk;

  accel_spi_ctrl #(.HALF_DIV(HALF), .GAP_CYC(GAP), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .drdy_i(drdy),
    .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .id_err_o(id_err), .smp_valid_o(valid), .smp_ready_i(ready),
    .smp_x_o(sx), .smp_y_o(sy), .smp_z_o(sz));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- sensor model (SPI mode 3 slave) ----------------
  logic [7:0] regs [64];
  logic [7:0] in_sh, out_sh, cmd;
  logic [5:0] addr;
  int bitc, frames, last_bits, wcount;
  logic [7:0] cmd_log [64];
  logic [5:0] wlog_a [8];
  logic [7:0] wlog_d [8];

  always @(negedge cs_n) begin
    bitc = 0;
    frames++;
  end
  always @(posedge cs_n) last_bits = bitc;

  always @(posedge sclk) if (!cs_n && rst_n) begin
    in_sh = {in_sh[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      if (bitc == 8) begin
        cmd = in_sh;
        if (frames >= 1 && frames <= 64) cmd_log[frames-1] = cmd;
        addr = cmd[5:0];
        if (cmd[7]) begin
          out_sh = regs[addr];
          if (cmd[6]) addr = addr + 6'd1;
        end
      end else if (!cmd[7]) begin
        if (bitc == 16) begin
          regs[addr] = in_sh;
          if (wcount < 8) begin
            wlog_a[wcount] = addr;
            wlog_d[wcount] = in_sh;
          end
          wcount++;
        end
      end else begin
        out_sh = regs[addr];
        if (cmd[6]) addr = addr + 6'd1;
      end
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    miso = out_sh[7];
    out_sh = {out_sh[6:0], 1'b0};
  end

  // ---------------- timing and stream monitor ----------------
  int cyc = 0, t_csf, t_rise, t_csr;
  bit seen_rel, first_fall;
  int lead_bad, trail_bad, gap_bad, rcount;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [47:0] rec [64];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      frames = 0; wcount = 0; last_bits = 0; seen_rel = 0;
      lead_bad = 0; trail_bad = 0; gap_bad = 0; rcount = 0;
    end else begin
      if (prev_cs && !cs_n) begin
        t_csf = cyc;
        first_fall = 1;
        if (seen_rel && (cyc - t_csr) < GAP) gap_bad++;
      end
      if (prev_sclk && !sclk && first_fall) begin
        if (cyc - t_csf != HALF) lead_bad++;
        first_fall = 0;
      end
      if (!prev_sclk && sclk) t_rise = cyc;
      if (!prev_cs && cs_n) begin
        if (cyc - t_rise != HALF) trail_bad++;
        t_csr = cyc;
        seen_rel = 1;
      end
      if (valid && ready) begin
        if (rcount < 64) rec[rcount] = {sx, sy, sz};
        rcount++;
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  // ---------------- helpers ----------------
  task automatic load_regs(input logic [47:0] v);
    regs[6'h32] = v[39:32]; regs[6'h33] = v[47:40];
    regs[6'h34] = v[23:16]; regs[6'h35] = v[31:24];
    regs[6'h36] = v[7:0];   regs[6'h37] = v[15:8];
  endtask

  task automatic pulse_drdy();
    @(negedge clk) drdy = 1'b1;
    repeat (6) @(negedge clk);
    drdy = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      if (valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [7:0] idv);
    regs[0] = idv;
    drdy = 1'b0;
    ready = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1, "R1", "reset cs_n", cs_n, 1);
    chk(sclk === 1'b1, "R1", "reset sclk", sclk, 1);
    chk(valid === 1'b0, "R7", "reset valid", valid, 0);
    chk(id_err === 1'b0, "R2", "reset id_err", id_err, 0);
    rst_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    bit got;
    int fb, rb;
    for (int i = 0; i < 64; i++) regs[i] = 8'h00;
    load_regs(48'h0);
    do_reset(8'hE5);

    // identity read and configuration
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (wcount == 3 && cs_n) break;
    end
    chk(cmd_log[0] == 8'h80, "R2", "identity command", cmd_log[0], 8'h80);
    chk(id_err == 1'b0, "R2", "no error on match", id_err, 0);
    chk(wcount == 3, "R3", "write count", wcount, 3);
    chk({wlog_a[0], wlog_d[0]} == {6'h31, 8'h0B}, "R3", "step 1", {wlog_a[0], wlog_d[0]}, {6'h31, 8'h0B});
    chk({wlog_a[1], wlog_d[1]} == {6'h2D, 8'h08}, "R3", "step 2", {wlog_a[1], wlog_d[1]}, {6'h2D, 8'h08});
    chk({wlog_a[2], wlog_d[2]} == {6'h2E, 8'h80}, "R3", "step 3", {wlog_a[2], wlog_d[2]}, {6'h2E, 8'h80});

    // edge during settle is discarded
    pulse_drdy();
    repeat (40) @(negedge clk);
    chk(frames == 4 && !valid, "R4", "no burst during settle", frames, 4);
    repeat (SETTLE + 300) @(negedge clk);
    chk(frames == 4 && rcount == 0, "R4", "settle edge not kept", frames, 4);

    // table walk
    ready = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      load_regs(VEC[v]);
      pulse_drdy();
      wait_valid(got);
      chk(got && {sx, sy, sz} == VEC[v], "R7", "sample set", {sx, sy, sz}, VEC[v]);
      @(negedge clk);
      chk(!valid, "R7", "valid one cycle", valid, 0);
      repeat (10) @(negedge clk);
      chk(cmd_log[frames-1] == 8'hF2, "R6", "burst command", cmd_log[frames-1], 8'hF2);
      chk(last_bits == 56, "R6", "burst length", last_bits, 56);
    end

    // level held high triggers once
    fb = frames; rb = rcount;
    load_regs(VEC[1]);
    @(negedge clk) drdy = 1'b1;
    repeat (800) @(negedge clk);
    chk(frames == fb + 1, "R5", "one frame for held level", frames, fb + 1);
    chk(rcount == rb + 1 && rec[rb] == VEC[1], "R5", "one sample for held level", rcount, rb + 1);
    drdy = 1'b0;
    repeat (10) @(negedge clk);

    // back-pressure and edge collision sweep
    for (int k = 0; k < 6; k++) begin
      ready = 1'b0;
      load_regs(VEC[2]);
      pulse_drdy();
      wait_valid(got);
      fb = frames;
      load_regs(VEC[3]);
      pulse_drdy();
      repeat (400) @(negedge clk);
      chk(valid && {sx, sy, sz} == VEC[2], "R8", "held sample", {sx, sy, sz}, VEC[2]);
      chk(frames == fb, "R8", "no burst while stalled", frames, fb);
      rb = rcount;
      ready = 1'b1;
      repeat (k) @(negedge clk);
      drdy = 1'b1;
      repeat (900) @(negedge clk);
      drdy = 1'b0;
      repeat (10) @(negedge clk);
      chk(rcount == rb + 3, "R8", $sformatf("sample count offset %0d", k), rcount, rb + 3);
      chk(rec[rb] == VEC[2] && rec[rb+1] == VEC[3] && rec[rb+2] == VEC[3], "R8",
          $sformatf("sample order offset %0d", k), rec[rb+2], VEC[3]);
    end

    chk(lead_bad == 0 && trail_bad == 0, "R1", "cs lead/trail", lead_bad + trail_bad, 0);
    chk(gap_bad == 0, "R1", "cs gap", gap_bad, 0);

    // identity mismatch
    do_reset(8'h5A);
    repeat (600) @(negedge clk);
    chk(id_err == 1'b1, "R2", "error on mismatch", id_err, 1);
    chk(frames == 1 && wcount == 0, "R2", "no frames after mismatch", frames, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule